// File: doc/BRIEF.md
# Multi-core spin-table release mailbox

This block is a bank of boot mailboxes, one per processor core. Each mailbox is a 32-byte entry. It holds a 64-bit jump address, a 64-bit argument and a 32-bit processor identifier, and the rest of the entry is reserved. Boot software on the primary core writes these entries through a single-cycle, big-endian register port. That port accepts byte, halfword and word accesses. Every secondary core polls its own entry.

A write to an entry can leave bit 0 of the jump address cleared. In that case the block releases the matching core: it raises that core's bit of a release vector for one cycle. In the same cycle it presents the launch parameters. These are the start offset inside a 64 MiB window, the 64 MiB-aligned window base, the window size and the argument value.

The release also stamps the core's own index back into the identifier field. Entry 0 belongs to the primary core, so writes to it have no effect. Entries at or above the number of populated cores can be read but not written.

Top module: `core_release_mbox`

## Requirements
- R1: After reset, entry i holds jump address 1, argument i and identifier i, and no release bit is set.
- R2: A write of size code 0 (1 byte), 1 (2 bytes) or 2 (4 bytes) to byte offset o of an entry changes only bytes o to o+n-1. The value is right-justified in the write data, and its most significant byte goes to offset o. Entry byte offsets are: 0–7 jump address, 8–15 argument, 20–23 identifier.
- R3: A read of size code 0, 1 or 2 returns the addressed bytes big-endian and right-justified in the read data, one cycle after the request. Reserved offsets 16–19 and 24–31 always read zero, and writes to them change nothing.
- R4: Writes to entry 0 change nothing and never release.
- R5: Writes to an entry whose index is not below the cores-present input change nothing and never release. Such entries stay readable.
- R6: An accepted write that leaves jump address bit 0 cleared sets exactly that entry's release bit for one cycle, in the cycle after the write. An accepted write that leaves bit 0 set releases nothing.
- R7: With the release bit, the block presents four values. The start offset is the jump address with bits 63..26 cleared. The window base is the jump address with bits 25..0 cleared. The window size is 0x4000000. The argument is the entry's argument field.
- R8: A release writes the entry's own index into its identifier field, replacing any value software stored there.
- R9: A read with size code 3 returns zero and raises the error flag for exactly one cycle.
- R10: Each further accepted write that leaves bit 0 cleared releases the same core again, one pulse per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cores_present | input | 6 | Number of populated cores |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address: entry index in bits 9..5, offset in bits 4..0 |
| bus_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 unsupported |
| bus_wdata | input | 32 | Right-justified write value |
| bus_rdata | output | 32 | Right-justified read value, valid the cycle after bus_rd |
| bus_err | output | 1 | One-cycle flag for an unsupported read size |
| rel_pulse | output | 32 | One-hot release vector, one bit per core |
| rel_start | output | 64 | Start offset inside the window |
| rel_base | output | 64 | 64 MiB-aligned window base |
| rel_arg | output | 64 | Argument for the released core |
| rel_size | output | 64 | Window size, constant 64 MiB |

## Verification
The assertions assume three things about the bus. Every access is naturally aligned to its size: halfwords at even offsets and words at multiples of four. Read and write are never requested in the same cycle. The bus_size value is meaningful only while a strobe is high. The directed bench holds to this by issuing each access from one task, which raises a single strobe for one cycle at an aligned offset. The cores-present input stays fixed at eight for the whole run, so the bench can target both populated and absent entries.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int ENTRY_BYTES = 32;
  localparam int ENTRY_BITS  = ENTRY_BYTES * 8;
  localparam int FLD_JUMP    = 0;
  localparam int FLD_ARG     = 8;
  localparam int FLD_IDENT   = 20;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [7:0]  en;
    logic [63:0] val;
  } lane64_t;

  typedef struct packed {
    logic [3:0]  en;
    logic [31:0] val;
  } lane32_t;

  // number of bytes touched by a size code
  function automatic int acc_bytes(logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction

  // steer write bytes into an 8-byte field starting at byte fb
  function automatic lane64_t steer64(logic [4:0] off, logic [1:0] sz,
                                      logic [31:0] wdata, int fb);
    lane64_t r;
    int n;
    r = '0;
    n = acc_bytes(sz);
    for (int k = 0; k < 4; k++) begin
      if (k < n) begin
        int idx;
        idx = int'(off) + k;
        if (idx >= fb && idx < fb + 8) begin
          r.en[idx - fb] = 1'b1;
          r.val[8*(7 - (idx - fb)) +: 8] = wdata[8*(n - 1 - k) +: 8];
        end
      end
    end
    return r;
  endfunction

  // steer write bytes into a 4-byte field starting at byte fb
  function automatic lane32_t steer32(logic [4:0] off, logic [1:0] sz,
                                      logic [31:0] wdata, int fb);
    lane32_t r;
    int n;
    r = '0;
    n = acc_bytes(sz);
    for (int k = 0; k < 4; k++) begin
      if (k < n) begin
        int idx;
        idx = int'(off) + k;
        if (idx >= fb && idx < fb + 4) begin
          r.en[idx - fb] = 1'b1;
          r.val[8*(3 - (idx - fb)) +: 8] = wdata[8*(n - 1 - k) +: 8];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] merge64(logic [63:0] old, lane64_t ln);
    logic [63:0] r;
    r = old;
    for (int p = 0; p < 8; p++)
      if (ln.en[p]) r[8*(7 - p) +: 8] = ln.val[8*(7 - p) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] merge32(logic [31:0] old, lane32_t ln);
    logic [31:0] r;
    r = old;
    for (int p = 0; p < 4; p++)
      if (ln.en[p]) r[8*(3 - p) +: 8] = ln.val[8*(3 - p) +: 8];
    return r;
  endfunction

  // pull a big-endian value out of an entry image, right-justified
  function automatic logic [31:0] extract(logic [ENTRY_BITS-1:0] img,
                                          logic [4:0] off, logic [1:0] sz);
    logic [31:0] r;
    int n;
    r = '0;
    n = acc_bytes(sz);
    for (int k = 0; k < 4; k++) begin
      if (k < n) begin
        int idx;
        idx = int'(off) + k;
        if (idx < ENTRY_BYTES)
          r[8*(n - 1 - k) +: 8] = img[8*(ENTRY_BYTES - 1 - idx) +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] win_offset(logic [63:0] a, int shift);
    return a & ((64'd1 << shift) - 64'd1);
  endfunction

  function automatic logic [63:0] win_base(logic [63:0] a, int shift);
    return a & ~((64'd1 << shift) - 64'd1);
  endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int N_SLOTS = 32,
  parameter int SLOT_W  = $clog2(N_SLOTS),
  parameter int ADDR_W  = SLOT_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic [SLOT_W:0]   cores_present,
  output logic [SLOT_W-1:0] slot_sel,
  output logic [4:0]        slot_off,
  output lane64_t           ln_jump,
  output lane64_t           ln_arg,
  output lane32_t           ln_ident,
  output logic              wr_accept,
  output logic [N_SLOTS-1:0] slot_wr
);

  assign slot_sel = bus_addr[ADDR_W-1:5];
  assign slot_off = bus_addr[4:0];

  assign ln_jump  = steer64(slot_off, bus_size, bus_wdata, FLD_JUMP);
  assign ln_arg   = steer64(slot_off, bus_size, bus_wdata, FLD_ARG);
  assign ln_ident = steer32(slot_off, bus_size, bus_wdata, FLD_IDENT);

  // primary core slot and unpopulated slots take no writes
  assign wr_accept = bus_wr && (slot_sel != '0) &&
                     ({1'b0, slot_sel} < cores_present);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_sel
    assign slot_wr[i] = wr_accept && (slot_sel == SLOT_W'(i));
  end

  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == SZ_HALF) |-> !bus_addr[0]); // R2

  AST_WR_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_wr)); // R6

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
  import mbox_pkg::*;
#(
  parameter int IDX = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  lane64_t               ln_jump,
  input  lane64_t               ln_arg,
  input  lane32_t               ln_ident,
  output logic [ENTRY_BITS-1:0] image,
  output logic [63:0]           next_jump,
  output logic [63:0]           next_arg,
  output logic                  fire
);

  logic [63:0] jump_q;
  logic [63:0] arg_q;
  logic [31:0] ident_q;
  logic [31:0] next_ident;

  assign next_jump  = merge64(jump_q, ln_jump);
  assign next_arg   = merge64(arg_q, ln_arg);
  assign next_ident = merge32(ident_q, ln_ident);

  // release when the merged jump address has its hold bit clear
  assign fire = wr_en && !next_jump[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jump_q  <= 64'd1;
      arg_q   <= 64'(IDX);
      ident_q <= 32'(IDX);
    end else if (wr_en) begin
      jump_q  <= next_jump;
      arg_q   <= next_arg;
      ident_q <= fire ? 32'(IDX) : next_ident;
    end
  end

  assign image = {jump_q, arg_q, 32'd0, ident_q, 64'd0};

  AST_FIRE_LEAVES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !jump_q[0]); // R6

  AST_HOLD_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && next_jump[0]) |=> jump_q[0]); // R6

  AST_IDENT_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ident_q == 32'(IDX))); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(jump_q) && $stable(arg_q))); // R4

endmodule

// File: rtl/mbox_release.sv
module mbox_release
  import mbox_pkg::*;
#(
  parameter int N_SLOTS   = 32,
  parameter int MAP_SHIFT = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] fire_vec,
  input  logic [63:0]        sel_jump,
  input  logic [63:0]        sel_arg,
  output logic [N_SLOTS-1:0] rel_pulse,
  output logic [63:0]        rel_start,
  output logic [63:0]        rel_base,
  output logic [63:0]        rel_arg,
  output logic [63:0]        rel_size
);

  localparam logic [63:0] WIN_SIZE = 64'd1 << MAP_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_pulse <= '0;
      rel_start <= '0;
      rel_base  <= '0;
      rel_arg   <= '0;
    end else begin
      rel_pulse <= fire_vec;
      if (|fire_vec) begin
        rel_start <= win_offset(sel_jump, MAP_SHIFT);
        rel_base  <= win_base(sel_jump, MAP_SHIFT);
        rel_arg   <= sel_arg;
      end
    end
  end

  assign rel_size = WIN_SIZE;

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_pulse)); // R6

  AST_SPLIT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> ((rel_start & rel_base) == 64'd0)); // R7

  AST_SPLIT_REJOIN: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> ((rel_start | rel_base) == $past(sel_jump))); // R7

endmodule

// File: rtl/core_release_mbox.sv
module core_release_mbox
  import mbox_pkg::*;
#(
  parameter int N_SLOTS   = 32,
  parameter int MAP_SHIFT = 26,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int ADDR_W   = SLOT_W + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLOT_W:0]    cores_present,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  output logic [N_SLOTS-1:0] rel_pulse,
  output logic [63:0]        rel_start,
  output logic [63:0]        rel_base,
  output logic [63:0]        rel_arg,
  output logic [63:0]        rel_size
);

  logic [SLOT_W-1:0]  slot_sel;
  logic [4:0]         slot_off;
  lane64_t            ln_jump, ln_arg;
  lane32_t            ln_ident;
  logic               wr_accept;
  logic [N_SLOTS-1:0] slot_wr;
  logic [N_SLOTS-1:0] fire_vec;
  logic [ENTRY_BITS-1:0] img_arr  [N_SLOTS];
  logic [63:0]        jump_arr [N_SLOTS];
  logic [63:0]        arg_arr  [N_SLOTS];
  logic [ENTRY_BITS-1:0] rd_img;

  mbox_decode #(.N_SLOTS(N_SLOTS)) u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_wdata     (bus_wdata),
    .cores_present (cores_present),
    .slot_sel      (slot_sel),
    .slot_off      (slot_off),
    .ln_jump       (ln_jump),
    .ln_arg        (ln_arg),
    .ln_ident      (ln_ident),
    .wr_accept     (wr_accept),
    .slot_wr       (slot_wr)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    mbox_slot #(.IDX(i)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (slot_wr[i]),
      .ln_jump   (ln_jump),
      .ln_arg    (ln_arg),
      .ln_ident  (ln_ident),
      .image     (img_arr[i]),
      .next_jump (jump_arr[i]),
      .next_arg  (arg_arr[i]),
      .fire      (fire_vec[i])
    );
  end

  mbox_release #(.N_SLOTS(N_SLOTS), .MAP_SHIFT(MAP_SHIFT)) u_release (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_vec  (fire_vec),
    .sel_jump  (jump_arr[slot_sel]),
    .sel_arg   (arg_arr[slot_sel]),
    .rel_pulse (rel_pulse),
    .rel_start (rel_start),
    .rel_base  (rel_base),
    .rel_arg   (rel_arg),
    .rel_size  (rel_size)
  );

  assign rd_img = img_arr[slot_sel];

  // registered read port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bus_rd && (bus_size == SZ_BAD);
      if (bus_rd)
        bus_rdata <= (bus_size == SZ_BAD) ? 32'd0 : extract(rd_img, slot_off, bus_size);
    end
  end

  AST_PRIMARY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_pulse[0]); // R4

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_pulse) |-> $past(wr_accept)); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd && bus_size == SZ_BAD)); // R9

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 32'd0)); // R9

  AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R3

endmodule

// File: tb/core_release_mbox_bench.sv
module core_release_mbox_bench;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cores_present = 6'd8;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [N-1:0] rel_pulse;
  logic [63:0] rel_start, rel_base, rel_arg, rel_size;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  core_release_mbox u_core_release_mbox (
    .clk (clk), .rst_n (rst_n), .cores_present (cores_present),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
    .bus_size (bus_size), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .bus_err (bus_err),
    .rel_pulse (rel_pulse), .rel_start (rel_start), .rel_base (rel_base),
    .rel_arg (rel_arg), .rel_size (rel_size)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(int slot, int off, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'(slot * 32 + off); bus_size = sz; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(int slot, int off, logic [1:0] sz,
                       output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 10'(slot * 32 + off); bus_size = sz;
    @(posedge clk); #1;
    d = bus_rdata; e = bus_err;
    bus_rd = 1'b0;
  endtask

  function automatic logic [63:0] exp_start(logic [63:0] a);
    return {38'd0, a[25:0]};
  endfunction
  function automatic logic [63:0] exp_base(logic [63:0] a);
    return {a[63:26], 26'd0};
  endfunction

  task automatic t_reset();
    logic [31:0] d; logic e;
    check("R1 no pulse", 64'(rel_pulse), 64'd0);
    do_rd(1, 20, 2'd2, d, e); check("R1 ident slot1", 64'(d), 64'd1);
    do_rd(7, 12, 2'd2, d, e); check("R1 arg slot7", 64'(d), 64'd7);
    do_rd(7, 4, 2'd2, d, e);  check("R1 jump lo slot7", 64'(d), 64'd1);
    do_rd(7, 0, 2'd2, d, e);  check("R1 jump hi slot7", 64'(d), 64'd0);
  endtask

  task automatic t_lanes();
    logic [31:0] d; logic e;
    do_wr(2, 15, 2'd0, 32'h0000_00AB);
    do_wr(2, 8, 2'd0, 32'h0000_0011);
    do_wr(2, 12, 2'd1, 32'h0000_5566);
    do_rd(2, 8, 2'd2, d, e);  check("R2 arg hi word", 64'(d), 64'h1100_0000);
    do_rd(2, 12, 2'd2, d, e); check("R2 arg lo word", 64'(d), 64'h5566_00AB);
    do_rd(2, 14, 2'd1, d, e); check("R3 half read", 64'(d), 64'h0000_00AB);
    do_rd(2, 12, 2'd0, d, e); check("R3 byte read", 64'(d), 64'h55);
  endtask

  task automatic t_reserved();
    logic [31:0] d; logic e;
    do_wr(2, 16, 2'd2, 32'hFFFF_FFFF);
    do_wr(2, 24, 2'd2, 32'hFFFF_FFFF);
    do_rd(2, 16, 2'd2, d, e); check("R3 reserved 16", 64'(d), 64'd0);
    do_rd(2, 24, 2'd2, d, e); check("R3 reserved 24", 64'(d), 64'd0);
    do_rd(2, 20, 2'd2, d, e); check("R3 ident untouched", 64'(d), 64'd2);
  endtask

  task automatic t_primary();
    logic [31:0] d; logic e;
    do_wr(0, 4, 2'd2, 32'h0000_0100);
    check("R4 no pulse slot0", 64'(rel_pulse), 64'd0);
    do_rd(0, 4, 2'd2, d, e); check("R4 slot0 jump kept", 64'(d), 64'd1);
  endtask

  task automatic t_absent();
    logic [31:0] d; logic e;
    do_wr(9, 4, 2'd2, 32'h0000_0000);
    check("R5 no pulse slot9", 64'(rel_pulse), 64'd0);
    do_wr(9, 20, 2'd2, 32'h0000_1234);
    do_rd(9, 4, 2'd2, d, e);  check("R5 slot9 jump kept", 64'(d), 64'd1);
    do_rd(9, 20, 2'd2, d, e); check("R5 slot9 ident kept", 64'(d), 64'd9);
  endtask

  task automatic t_release();
    logic [63:0] a;
    a = 64'h0000_0001_0A12_3458;
    do_wr(3, 8, 2'd2, 32'h0);
    do_wr(3, 12, 2'd2, 32'hCAFE_0003);
    do_wr(3, 0, 2'd2, a[63:32]);
    check("R6 held hi write", 64'(rel_pulse), 64'd0);
    do_wr(3, 4, 2'd2, a[31:0]);
    check("R6 pulse slot3", 64'(rel_pulse), 64'(32'd1 << 3));
    check("R7 start", rel_start, exp_start(a));
    check("R7 base", rel_base, exp_base(a));
    check("R7 arg", rel_arg, 64'h0000_0000_CAFE_0003);
    check("R7 size", rel_size, 64'h0000_0000_0400_0000);
    @(posedge clk); #1;
    check("R6 pulse one cycle", 64'(rel_pulse), 64'd0);
  endtask

  task automatic t_ident();
    logic [31:0] d; logic e;
    do_wr(5, 20, 2'd2, 32'hDEAD_BEEF);
    do_rd(5, 20, 2'd2, d, e); check("R8 ident stored", 64'(d), 64'hDEAD_BEEF);
    do_wr(5, 4, 2'd2, 32'h0000_1000);
    check("R8 pulse slot5", 64'(rel_pulse), 64'(32'd1 << 5));
    do_rd(5, 20, 2'd2, d, e); check("R8 ident restamped", 64'(d), 64'd5);
  endtask

  task automatic t_repeat();
    do_wr(4, 4, 2'd2, 32'h0000_0100);
    check("R10 first pulse", 64'(rel_pulse), 64'(32'd1 << 4));
    check("R10 first start", rel_start, 64'h100);
    do_wr(4, 4, 2'd2, 32'h0000_0200);
    check("R10 second pulse", 64'(rel_pulse), 64'(32'd1 << 4));
    check("R10 second start", rel_start, 64'h200);
    do_wr(4, 4, 2'd2, 32'h0000_0011);
    check("R6 bit0 set no pulse", 64'(rel_pulse), 64'd0);
  endtask

  task automatic t_bytedrop();
    do_wr(6, 7, 2'd0, 32'h0);
    check("R2 byte clears hold", 64'(rel_pulse), 64'(32'd1 << 6));
    check("R7 zero start", rel_start, 64'd0);
    check("R7 zero base", rel_base, 64'd0);
    check("R7 arg slot6", rel_arg, 64'd6);
  endtask

  task automatic t_badsize();
    logic [31:0] d; logic e;
    do_rd(1, 20, 2'd3, d, e);
    check("R9 data zero", 64'(d), 64'd0);
    check("R9 err set", 64'(e), 64'd1);
    @(posedge clk); #1;
    check("R9 err one cycle", 64'(bus_err), 64'd0);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_lanes();
    t_reserved();
    t_primary();
    t_absent();
    t_release();
    t_ident();
    t_repeat();
    t_bytedrop();
    t_badsize();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule